// File: doc/BRIEF.md
# Keyed-Unlock Watchdog Reset Timer

This block is a watchdog timer that requests a system reset. It has a 64-bit up-counter and a 64-bit limit. Both are reached through a 32-bit register port as low and high words. Arming takes two steps. Software writes an opening key and then a committing key into the control word, and each of those writes must also set the enable bit. The watchdog then moves from idle to pre-active, and from pre-active to active.

Once the watchdog is active, it cannot be switched off. While active, the counter advances on every clock. Software keeps the chip alive by writing the opening key and then the committing key again, which clears the counter. The block fires if the counter ever equals the limit, or if a control write carries a key that is neither of the two known values. When it fires, it raises a reset request for a fixed number of clocks and locks in a fired state. Only the block's own reset input leaves the fired state.

Top module: `wdg_reset_timer`

## Requirements
- R1: After reset the watchdog is idle. The control word reads 0, both counter words and both limit words read 0, and `rst_req` is low.
- R2: The control word carries the key in bits 31:16 and the enable bit in bit 14. In idle, only a write of key 0xA5C6 with the enable bit set leads to pre-active. Any other control write leaves the watchdog idle.
- R3: In pre-active, a write of key 0xDA7E with the enable bit set leads to active. Any other control write returns the watchdog to idle and leaves `rst_req` low.
- R4: In active, a control write whose key is neither 0xA5C6 nor 0xDA7E fires the watchdog. `rst_req` is high from the clock edge that takes that write.
- R5: The 64-bit counter rises by one per clock only while the watchdog is active, with carry from the low word into the high word. In idle and pre-active it holds its value unless software writes it.
- R6: In active, a counter value equal to the limit fires the watchdog. `rst_req` rises one edge after the counter reaches the limit. With a counter preload c0 and a limit P, that edge is P − c0 + 1 edges after activation, so a limit of 0 fires on the first edge after activation.
- R7: In active, a write of key 0xA5C6 followed by a write of key 0xDA7E services the watchdog. The counter reads 0 after the second write.
- R8: In active, software cannot leave the active state, even with the enable bit clear. Writes to the counter and limit words have no effect.
- R9: A firing holds `rst_req` high for exactly 16 clocks, and only once. The watchdog then stays fired and ignores all writes until `rst_n` is asserted.
- R10: Register word addresses are: 0 control, 1 counter low, 2 counter high, 3 limit low, 4 limit high. A control read returns the state in bits 1:0 (idle 0, pre-active 1, active 2, fired 3) and bit 14 set when active or fired. Counter and limit words load from `wdata` in idle and pre-active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| rst_req | output | 1 | Registered reset request pulse |

## Verification
On every cycle, the assertions check the following:
- An active watchdog advances its counter by one, and an idle or pre-active one holds it.
- A bad key or a counter equal to the limit in active raises `rst_req` on the next edge.
- Active and fired are never left except through reset.
- A pre-active watchdog never raises a request.
- Each request lasts exactly 16 clocks.

Only the bench scenarios can show that the key ordering and the enable bit are decoded at the stated bit positions, that the firing edge follows P − c0 + 1 for random limits and preloads, that a service pair zeroes the counter and restarts the count, and that locked writes leave the readable limit unchanged.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  localparam logic [15:0] KEY_OPEN   = 16'hA5C6;
  localparam logic [15:0] KEY_COMMIT = 16'hDA7E;

  typedef enum logic [1:0] {
    WS_IDLE   = 2'd0,
    WS_PRE    = 2'd1,
    WS_ACTIVE = 2'd2,
    WS_FIRED  = 2'd3
  } wdg_state_e;

  localparam logic [2:0] RA_CTRL   = 3'd0;
  localparam logic [2:0] RA_CNT_LO = 3'd1;
  localparam logic [2:0] RA_CNT_HI = 3'd2;
  localparam logic [2:0] RA_PER_LO = 3'd3;
  localparam logic [2:0] RA_PER_HI = 3'd4;

  function automatic logic key_known(input logic [15:0] k);
    return (k == KEY_OPEN) || (k == KEY_COMMIT);
  endfunction

endpackage

// File: rtl/wdg_key_fsm.sv
module wdg_key_fsm
  import wdg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_wr,
  input  logic [15:0] key,
  input  logic        ena,
  input  logic        timeout,
  output wdg_state_e  state_o,
  output logic        svc_clr,
  output logic        bite
);

  wdg_state_e state_q, state_d;
  logic       half_q, half_d;

  always_comb begin
    state_d = state_q;
    half_d  = half_q;
    svc_clr = 1'b0;
    bite    = 1'b0;
    unique case (state_q)
      WS_IDLE: begin
        if (ctrl_wr && ena && key == KEY_OPEN) state_d = WS_PRE;
        half_d = 1'b0;
      end
      WS_PRE: begin
        if (ctrl_wr) state_d = (ena && key == KEY_COMMIT) ? WS_ACTIVE : WS_IDLE;
        half_d = 1'b0;
      end
      WS_ACTIVE: begin
        if (timeout || (ctrl_wr && !key_known(key))) begin
          bite    = 1'b1;
          state_d = WS_FIRED;
        end else if (ctrl_wr) begin
          if (key == KEY_OPEN) begin
            half_d = 1'b1;
          end else if (half_q) begin
            svc_clr = 1'b1;
            half_d  = 1'b0;
          end
        end
      end
      default: state_d = WS_FIRED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WS_IDLE;
      half_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      half_q  <= half_d;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int REG_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               clr,
  input  logic               wr_cnt_lo,
  input  logic               wr_cnt_hi,
  input  logic               wr_per_lo,
  input  logic               wr_per_hi,
  input  logic [REG_W-1:0]   wdata,
  output logic [2*REG_W-1:0] cnt_o,
  output logic [2*REG_W-1:0] per_o,
  output logic               hit
);

  localparam int CW = 2 * REG_W;

  logic [CW-1:0] cnt_q, cnt_d, per_q, per_d;

  function automatic logic [CW-1:0] count_next(input logic [CW-1:0] cur,
                                               input logic run_i,
                                               input logic clr_i);
    if (clr_i)      return '0;
    else if (run_i) return cur + CW'(1);
    else            return cur;
  endfunction

  always_comb begin
    cnt_d = count_next(cnt_q, run, clr);
    per_d = per_q;
    if (wr_cnt_lo) cnt_d[REG_W-1:0]  = wdata;
    if (wr_cnt_hi) cnt_d[CW-1:REG_W] = wdata;
    if (wr_per_lo) per_d[REG_W-1:0]  = wdata;
    if (wr_per_hi) per_d[CW-1:REG_W] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      per_q <= per_d;
    end
  end

  assign cnt_o = cnt_q;
  assign per_o = per_q;
  assign hit   = (cnt_q == per_q);

endmodule

// File: rtl/wdg_pulse.sv
module wdg_pulse #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);

  localparam int LW = $clog2(PULSE_LEN + 1);

  logic [LW-1:0] left_q;
  logic          pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q  <= '0;
      pulse_q <= 1'b0;
    end else if (fire) begin
      left_q  <= LW'(PULSE_LEN - 1);
      pulse_q <= 1'b1;
    end else if (left_q != '0) begin
      left_q  <= left_q - LW'(1);
      pulse_q <= 1'b1;
    end else begin
      pulse_q <= 1'b0;
    end
  end

  assign pulse = pulse_q;

endmodule

// File: rtl/wdg_reset_timer.sv
module wdg_reset_timer
  import wdg_pkg::*;
#(
  parameter int REG_W     = 32,
  parameter int PULSE_LEN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             rst_req
);

  localparam int CW      = 2 * REG_W;
  localparam int KEY_LSB = REG_W - 16;
  localparam int ENA_BIT = 14;

  wdg_state_e    state;
  logic          ctrl_wr, wr_allow, svc_clr, bite, hit;
  logic          wr_cnt_lo, wr_cnt_hi, wr_per_lo, wr_per_hi, cnt_wr_any;
  logic [15:0]   wkey;
  logic [CW-1:0] cnt, per;

  assign ctrl_wr    = wr_en && (addr == RA_CTRL);
  assign wkey       = wdata[REG_W-1:KEY_LSB];
  assign wr_allow   = (state == WS_IDLE) || (state == WS_PRE);
  assign wr_cnt_lo  = wr_en && wr_allow && (addr == RA_CNT_LO);
  assign wr_cnt_hi  = wr_en && wr_allow && (addr == RA_CNT_HI);
  assign wr_per_lo  = wr_en && wr_allow && (addr == RA_PER_LO);
  assign wr_per_hi  = wr_en && wr_allow && (addr == RA_PER_HI);
  assign cnt_wr_any = wr_cnt_lo || wr_cnt_hi;

  wdg_key_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl_wr (ctrl_wr),
    .key     (wkey),
    .ena     (wdata[ENA_BIT]),
    .timeout (hit),
    .state_o (state),
    .svc_clr (svc_clr),
    .bite    (bite)
  );

  wdg_counter #(.REG_W(REG_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (state == WS_ACTIVE),
    .clr       (svc_clr),
    .wr_cnt_lo (wr_cnt_lo),
    .wr_cnt_hi (wr_cnt_hi),
    .wr_per_lo (wr_per_lo),
    .wr_per_hi (wr_per_hi),
    .wdata     (wdata),
    .cnt_o     (cnt),
    .per_o     (per),
    .hit       (hit)
  );

  wdg_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (bite),
    .pulse (rst_req)
  );

  function automatic logic [REG_W-1:0] ctrl_view(input wdg_state_e s);
    logic [REG_W-1:0] v;
    v          = '0;
    v[1:0]     = s;
    v[ENA_BIT] = (s == WS_ACTIVE) || (s == WS_FIRED);
    return v;
  endfunction

  always_comb begin
    unique case (addr)
      RA_CTRL:   rdata = ctrl_view(state);
      RA_CNT_LO: rdata = cnt[REG_W-1:0];
      RA_CNT_HI: rdata = cnt[CW-1:REG_W];
      RA_PER_LO: rdata = per[REG_W-1:0];
      RA_PER_HI: rdata = per[CW-1:REG_W];
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/wdg_reset_timer_chk.sv
module wdg_reset_timer_chk
  import wdg_pkg::*;
#(
  parameter int REG_W     = 32,
  parameter int PULSE_LEN = 16
) (
  input logic               clk,
  input logic               rst_n,
  input wdg_state_e         state,
  input logic [2*REG_W-1:0] cnt,
  input logic [2*REG_W-1:0] per,
  input logic               ctrl_wr,
  input logic [15:0]        wkey,
  input logic               svc_clr,
  input logic               cnt_wr_any,
  input logic               rst_req
);

  int hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_len <= 0;
    else if (rst_req) hi_len <= hi_len + 1;
  end

  p_fire_on_badkey_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WS_ACTIVE && ctrl_wr && wkey != KEY_OPEN && wkey != KEY_COMMIT) |=> rst_req);

  p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WS_ACTIVE && !svc_clr) |=> (cnt == $past(cnt) + 1));

  p_count_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == WS_IDLE || state == WS_PRE) && !cnt_wr_any) |=> $stable(cnt));

  p_limit_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WS_ACTIVE && cnt == per) |=> rst_req);

  p_pre_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WS_PRE) |=> !$rose(rst_req));

  p_no_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WS_ACTIVE) |=> (state == WS_ACTIVE || state == WS_FIRED));

  p_fired_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == WS_FIRED) |=> (state == WS_FIRED));

  p_pulse_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req) |-> (hi_len == PULSE_LEN));

endmodule

bind wdg_reset_timer wdg_reset_timer_chk #(.REG_W(REG_W), .PULSE_LEN(PULSE_LEN)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .state      (state),
  .cnt        (cnt),
  .per        (per),
  .ctrl_wr    (ctrl_wr),
  .wkey       (wkey),
  .svc_clr    (svc_clr),
  .cnt_wr_any (cnt_wr_any),
  .rst_req    (rst_req)
);

// File: tb/wdg_reset_timer_tb_top.sv
module wdg_reset_timer_tb_top;

  localparam logic [31:0] K_OPEN   = 32'hA5C6_4000;
  localparam logic [31:0] K_COMMIT = 32'hDA7E_4000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic        rst_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wdg_reset_timer dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .rst_req (rst_req)
  );

  function automatic int fire_delay(input longint p, input longint c0);
    return int'(p - c0 + 1);
  endfunction

  function automatic logic [31:0] ctrl_word(input int st);
    logic [31:0] v;
    v = 32'(st);
    if (st >= 2) v[14] = 1'b1;
    return v;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    addr  = a;
    wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic poll_fire(output int n);
    n = 0;
    while (!rst_req && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int n;
    int hi;
    void'($urandom(32'd1234));

    do_reset();
    rd(3'd0, v); check("R1 ctrl", v, 0);
    rd(3'd1, v); check("R1 cnt_lo", v, 0);
    rd(3'd2, v); check("R1 cnt_hi", v, 0);
    rd(3'd3, v); check("R1 per_lo", v, 0);
    rd(3'd4, v); check("R1 per_hi", v, 0);
    check("R1 rst_req", rst_req, 0);

    // R2: key order and enable bit in idle
    wr(3'd0, K_COMMIT);           rd(3'd0, v); check("R2 commit in idle", v, ctrl_word(0));
    wr(3'd0, 32'hA5C6_0000);      rd(3'd0, v); check("R2 no enable", v, ctrl_word(0));
    wr(3'd0, K_OPEN);             rd(3'd0, v); check("R2 to pre", v, ctrl_word(1));

    // R5: counter holds in pre-active
    wr(3'd1, 32'd7);
    repeat (5) @(negedge clk);
    rd(3'd1, v); check("R5 hold in pre", v, 7);

    // R3: wrong key in pre-active returns to idle, no request
    wr(3'd0, 32'h1234_4000);      rd(3'd0, v); check("R3 back to idle", v, ctrl_word(0));
    check("R3 no rst_req", rst_req, 0);

    // R3/R8: arm with a large limit, then try to change things
    wr(3'd3, 32'd1000);
    wr(3'd1, 32'd0);
    wr(3'd0, K_OPEN);
    wr(3'd0, K_COMMIT);           rd(3'd0, v); check("R3 to active", v, ctrl_word(2));
    rd(3'd1, v); check("R5 counts in active", v, 0);
    @(negedge clk);
    rd(3'd1, v); check("R5 one step", v, 1);
    wr(3'd3, 32'd5);              rd(3'd3, v); check("R8 limit locked", v, 1000);
    wr(3'd0, 32'hA5C6_0000);      rd(3'd0, v); check("R8 no disable", v, ctrl_word(2));

    // R4: bad key fires immediately
    wr(3'd0, 32'h0000_4000);
    check("R4 rst_req", rst_req, 1);
    rd(3'd0, v); check("R4 fired state", v, ctrl_word(3));

    // R9: pulse length, then sticky fired state
    hi = 0;
    while (rst_req && hi < 100) begin
      hi++;
      @(negedge clk);
    end
    check("R9 pulse length", hi, 16);
    wr(3'd0, K_OPEN);
    wr(3'd0, K_COMMIT);
    wr(3'd0, 32'h0);
    repeat (20) @(negedge clk);
    rd(3'd0, v); check("R9 stays fired", v, ctrl_word(3));
    check("R9 single pulse", rst_req, 0);

    // R6: limit 0 fires on first edge after activation
    do_reset();
    wr(3'd0, K_OPEN);
    wr(3'd0, K_COMMIT);
    poll_fire(n);
    check("R6 zero limit", n, fire_delay(0, 0));

    // R10/R5: carry across halves and limit above 2^32
    do_reset();
    wr(3'd1, 32'hFFFF_FFFE);
    wr(3'd3, 32'd5);
    wr(3'd4, 32'd1);
    rd(3'd4, v); check("R10 per_hi load", v, 1);
    wr(3'd0, K_OPEN);
    wr(3'd0, K_COMMIT);
    repeat (2) @(negedge clk);
    rd(3'd2, v); check("R10 carry hi", v, 1);
    rd(3'd1, v); check("R10 carry lo", v, 0);
    poll_fire(n);
    check("R6 wide limit", n + 2, fire_delay(64'h1_0000_0005, 64'hFFFF_FFFE));

    // Random limits, preloads and services
    for (int it = 0; it < 12; it++) begin
      int p, c0, d;
      bit svc;
      p   = 10 + int'($urandom % 31);
      c0  = int'($urandom % (p / 2));
      d   = int'($urandom % (p - c0 - 2));
      svc = 1'($urandom % 2);
      do_reset();
      wr(3'd3, 32'(p));
      wr(3'd1, 32'(c0));
      wr(3'd0, K_OPEN);
      wr(3'd0, K_COMMIT);
      if (svc) begin
        repeat (d) @(negedge clk);
        wr(3'd0, K_OPEN);
        wr(3'd0, K_COMMIT);
        rd(3'd1, v); check("R7 service clears", v, 0);
        poll_fire(n);
        check("R7 fire after service", n, fire_delay(p, 0));
      end else begin
        poll_fire(n);
        check("R6 random limit", n, fire_delay(p, c0));
      end
    end

    finish_run();
  end

endmodule